// File: doc/BRIEF.md
# PHY Register Port Handshake Master

This block carries out single register reads and writes on the control port of a SerDes that contains several PHYs. Each PHY has its own parallel register port: an address bus, a write-data bus, read and write enables, a select line, an acknowledge input and a read-data input. Transfers on this port follow a four-phase handshake. The block raises an enable and waits for the acknowledge to rise. It then drops the enable and waits for the acknowledge to fall. Each of the two waits has its own bounded poll, and the block reports which wait ran out.

A host offers one request at a time with a valid/ready pair. A request carries the PHY index, a read/write flag, the register address and the write data. While an operation is in flight the block shows busy and takes no new request. When the operation finishes, the block gives a one-cycle done pulse together with a status code and, for reads, the captured data. The acknowledge is polled at a fixed spacing, measured in microseconds and derived from the clock frequency parameter. The first access to a PHY also raises that PHY's select line and waits a settle time before any enable is driven.

Top module: `phy_regport_master`

## Requirements
- R1: After reset, req_ready_o is 1, busy_o is 0, done_o is 0, and every PHY select, read enable and write enable is 0.
- R2: A request is taken only when req_ready_o is 1. While busy_o is 1, req_ready_o is 0, and a request offered during that time has no effect on any PHY register.
- R3: On the first access to PHY n after reset, phy_sel_o[n] rises and stays high until the next reset. No enable of PHY n rises until SETTLE_US microseconds later. Later accesses to PHY n skip the settle wait. The other PHYs' selects, enables and buses stay 0.
- R4: On a write, the address and write data are on the addressed PHY's buses one cycle before its write enable rises. The write enable is held until the acknowledge is sampled high and is then dropped.
- R5: On a read, the read enable is held until the acknowledge is sampled high. The PHY read data sampled on that same poll appears on rdata_o from the done pulse onward. rdata_o is not changed by writes.
- R6: The first acknowledge poll of each wait happens in the first cycle of that wait. Later polls follow every POLL_US microseconds, with at most MAX_POLLS polls per wait. In clock cycles (S = settle cycles, P = poll spacing cycles), a failed first wait ends after S+2+(MAX_POLLS-1)*P cycles on a first access and after 2+(MAX_POLLS-1)*P cycles otherwise.
- R7: err_code_o is updated at each done pulse: 0 means success, 1 a read acknowledge timeout, 2 a read release timeout, 3 a write acknowledge timeout and 4 a write release timeout. At done, all enables are 0 and the block is idle.
- R8: done_o is a single-cycle pulse, and a successful operation reports code 0.
- R9: At most one enable, read or write, of one PHY, is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken |
| req_phy_i | input | IDX_W | Target PHY index, below NUM_PHY |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 3 | Completion status |
| rdata_o | output | DATA_W | Data of the last successful read |
| phy_sel_o | output | NUM_PHY | Per-PHY register port select |
| phy_addr_o | output | NUM_PHY*ADDR_W | Per-PHY address bus |
| phy_wdata_o | output | NUM_PHY*DATA_W | Per-PHY write data bus |
| phy_rd_en_o | output | NUM_PHY | Per-PHY read enable |
| phy_wr_en_o | output | NUM_PHY | Per-PHY write enable |
| phy_ack_i | input | NUM_PHY | Per-PHY acknowledge |
| phy_rdata_i | input | NUM_PHY*DATA_W | Per-PHY read data |

## Verification
The assertions take for granted that a PHY's acknowledge moves only in answer to its own enable. It rises some time after the enable rises and falls some time after the enable falls, unless a fault holds it. They also assume the request index is always below NUM_PHY. The bench PHY model follows the four-phase rule with rise and fall delays drawn within three poll periods, and it breaks the rule only on purpose, by pinning the acknowledge low or high to force each of the four timeouts. Random requests use only in-range PHY indices and offer a new request only while the block is idle. The one exception is a deliberate offer during busy.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACK    = 3'd3,
    ST_UNACK  = 3'd4
  } xfer_state_t;

  // Completion status; values are visible at the top-level port
  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_RD_ACK   = 3'd1,
    ERR_RD_UNACK = 3'd2,
    ERR_WR_ACK   = 3'd3,
    ERR_WR_UNACK = 3'd4
  } xfer_err_t;

endpackage

// File: rtl/pr_pace_timer.sv
// Loadable down-counter shared by the settle wait and the poll spacing.
module pr_pace_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pr_phy_fanout.sv
// Routes the single active transfer to one PHY port and picks its responses.
module pr_phy_fanout #(
  parameter int NUM_PHY = 2,
  parameter int IDX_W   = 1,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      drive_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [NUM_PHY-1:0]        phy_ack_i,
  input  logic [NUM_PHY*DATA_W-1:0] phy_rdata_i,
  output logic [NUM_PHY*ADDR_W-1:0] phy_addr_o,
  output logic [NUM_PHY*DATA_W-1:0] phy_wdata_o,
  output logic [NUM_PHY-1:0]        phy_rd_en_o,
  output logic [NUM_PHY-1:0]        phy_wr_en_o,
  output logic                      ack_o,
  output logic [DATA_W-1:0]         rdata_o
);

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_port
    logic hit;
    assign hit = drive_i && (idx_i == IDX_W'(g));
    assign phy_addr_o[g*ADDR_W +: ADDR_W]  = hit ? addr_i  : '0;
    assign phy_wdata_o[g*DATA_W +: DATA_W] = hit ? wdata_i : '0;
    assign phy_rd_en_o[g] = hit && rd_i;
    assign phy_wr_en_o[g] = hit && wr_i;
  end

  always_comb begin
    ack_o   = 1'b0;
    rdata_o = '0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (idx_i == IDX_W'(i)) begin
        ack_o   = phy_ack_i[i];
        rdata_o = phy_rdata_i[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/pr_ctrl.sv
// Transfer sequencer: settle, setup, acknowledge wait, release wait.
module pr_ctrl
  import phyreg_pkg::*;
#(
  parameter int NUM_PHY    = 2,
  parameter int IDX_W      = 1,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MAX_POLLS  = 10,
  parameter int POLL_CYC   = 1250,
  parameter int SETTLE_CYC = 125,
  parameter int TMR_W      = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [IDX_W-1:0]   req_phy_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2:0]         err_code_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_PHY-1:0] sel_o,
  output logic [IDX_W-1:0]   cur_phy_o,
  output logic [ADDR_W-1:0]  cur_addr_o,
  output logic [DATA_W-1:0]  cur_wdata_o,
  output logic               drive_o,
  output logic               rd_o,
  output logic               wr_o,
  input  logic               ack_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic               tmr_load_o,
  output logic [TMR_W-1:0]   tmr_val_o,
  input  logic               tmr_zero_i
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  xfer_state_t        state_q, state_d;
  xfer_err_t          err_q, err_d;
  logic [IDX_W-1:0]   phy_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               write_q, done_q;
  logic [NUM_PHY-1:0] sel_q, sel_d;
  logic [CNT_W-1:0]   poll_q, poll_d;
  logic               lat_en, cap_en, fin_en, last_poll;

  assign last_poll = (poll_q == CNT_W'(MAX_POLLS - 1));

  always_comb begin
    state_d    = state_q;
    poll_d     = poll_q;
    sel_d      = sel_q;
    err_d      = ERR_NONE;
    lat_en     = 1'b0;
    cap_en     = 1'b0;
    fin_en     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          lat_en = 1'b1;
          if (sel_q[req_phy_i]) begin
            state_d = ST_SETUP;
          end else begin
            sel_d[req_phy_i] = 1'b1;
            state_d          = ST_SETTLE;
            tmr_load_o       = 1'b1;
            tmr_val_o        = TMR_W'(SETTLE_CYC - 1);
          end
        end
      end
      ST_SETTLE: if (tmr_zero_i) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d    = ST_ACK;
        poll_d     = '0;
        tmr_load_o = 1'b1;
      end
      ST_ACK: begin
        if (tmr_zero_i) begin
          if (ack_i) begin
            state_d    = ST_UNACK;
            poll_d     = '0;
            tmr_load_o = 1'b1;
            cap_en     = !write_q;
          end else if (last_poll) begin
            state_d = ST_IDLE;
            fin_en  = 1'b1;
            err_d   = write_q ? ERR_WR_ACK : ERR_RD_ACK;
          end else begin
            poll_d     = poll_q + 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = TMR_W'(POLL_CYC - 1);
          end
        end
      end
      ST_UNACK: begin
        if (tmr_zero_i) begin
          if (!ack_i) begin
            state_d = ST_IDLE;
            fin_en  = 1'b1;
          end else if (last_poll) begin
            state_d = ST_IDLE;
            fin_en  = 1'b1;
            err_d   = write_q ? ERR_WR_UNACK : ERR_RD_UNACK;
          end else begin
            poll_d     = poll_q + 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = TMR_W'(POLL_CYC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
      phy_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      sel_q   <= sel_d;
      done_q  <= fin_en;
      if (fin_en) err_q <= err_d;
      if (lat_en) begin
        phy_q   <= req_phy_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        write_q <= req_write_i;
      end
      if (cap_en) rdata_q <= rdata_i;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = !req_ready_o;
  assign done_o      = done_q;
  assign err_code_o  = err_q;
  assign rdata_o     = rdata_q;
  assign sel_o       = sel_q;
  assign cur_phy_o   = phy_q;
  assign cur_addr_o  = addr_q;
  assign cur_wdata_o = wdata_q;
  assign drive_o     = (state_q != ST_IDLE);
  assign rd_o        = (state_q == ST_ACK) && !write_q;
  assign wr_o        = (state_q == ST_ACK) && write_q;

endmodule

// File: rtl/phy_regport_master.sv
module phy_regport_master #(
  parameter int NUM_PHY   = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CLK_HZ    = 125_000_000,
  parameter int POLL_US   = 10,
  parameter int SETTLE_US = 1,
  parameter int MAX_POLLS = 10,
  localparam int IDX_W    = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [IDX_W-1:0]          req_phy_i,
  input  logic                      req_write_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [2:0]                err_code_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_PHY-1:0]        phy_sel_o,
  output logic [NUM_PHY*ADDR_W-1:0] phy_addr_o,
  output logic [NUM_PHY*DATA_W-1:0] phy_wdata_o,
  output logic [NUM_PHY-1:0]        phy_rd_en_o,
  output logic [NUM_PHY-1:0]        phy_wr_en_o,
  input  logic [NUM_PHY-1:0]        phy_ack_i,
  input  logic [NUM_PHY*DATA_W-1:0] phy_rdata_i
);

  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int POLL_CYC   = (CYC_PER_US * POLL_US > 0) ? CYC_PER_US * POLL_US : 1;
  localparam int SETTLE_CYC = (CYC_PER_US * SETTLE_US > 0) ? CYC_PER_US * SETTLE_US : 1;
  localparam int TMR_MAX    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  logic [IDX_W-1:0]  cur_phy;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata, sel_rdata;
  logic              drive, rd, wr, sel_ack;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;

  pr_ctrl #(
    .NUM_PHY(NUM_PHY), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAX_POLLS(MAX_POLLS), .POLL_CYC(POLL_CYC), .SETTLE_CYC(SETTLE_CYC),
    .TMR_W(TMR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_phy_i(req_phy_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_code_o(err_code_o),
    .rdata_o(rdata_o), .sel_o(phy_sel_o),
    .cur_phy_o(cur_phy), .cur_addr_o(cur_addr), .cur_wdata_o(cur_wdata),
    .drive_o(drive), .rd_o(rd), .wr_o(wr),
    .ack_i(sel_ack), .rdata_i(sel_rdata),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .tmr_zero_i(tmr_zero)
  );

  pr_pace_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  pr_phy_fanout #(
    .NUM_PHY(NUM_PHY), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_fanout (
    .idx_i(cur_phy), .drive_i(drive), .addr_i(cur_addr), .wdata_i(cur_wdata),
    .rd_i(rd), .wr_i(wr),
    .phy_ack_i(phy_ack_i), .phy_rdata_i(phy_rdata_i),
    .phy_addr_o(phy_addr_o), .phy_wdata_o(phy_wdata_o),
    .phy_rd_en_o(phy_rd_en_o), .phy_wr_en_o(phy_wr_en_o),
    .ack_o(sel_ack), .rdata_o(sel_rdata)
  );

endmodule

// File: rtl/phy_regport_master_chk.sv
module phy_regport_master_chk #(
  parameter int NUM_PHY = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid_i,
  input logic                      req_ready_o,
  input logic                      busy_o,
  input logic                      done_o,
  input logic [NUM_PHY-1:0]        phy_sel_o,
  input logic [NUM_PHY*ADDR_W-1:0] phy_addr_o,
  input logic [NUM_PHY*DATA_W-1:0] phy_wdata_o,
  input logic [NUM_PHY-1:0]        phy_rd_en_o,
  input logic [NUM_PHY-1:0]        phy_wr_en_o,
  input logic [NUM_PHY-1:0]        phy_ack_i
);

  logic any_en;
  assign any_en = |{phy_rd_en_o, phy_wr_en_o};

  assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o |=> busy_o);

  assert_en_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_rd_en_o | phy_wr_en_o) & ~phy_sel_o) == '0);

  assert_sel_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_en) |-> $stable(phy_sel_o));

  assert_bus_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_en) |-> $stable(phy_addr_o) && $stable(phy_wdata_o));

  assert_drop_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_en) |-> $past(|phy_ack_i) || done_o);

  assert_quiet_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !any_en && !busy_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_one_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({phy_rd_en_o, phy_wr_en_o}) <= 1);

endmodule

bind phy_regport_master phy_regport_master_chk #(
  .NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .busy_o(busy_o), .done_o(done_o),
  .phy_sel_o(phy_sel_o), .phy_addr_o(phy_addr_o), .phy_wdata_o(phy_wdata_o),
  .phy_rd_en_o(phy_rd_en_o), .phy_wr_en_o(phy_wr_en_o), .phy_ack_i(phy_ack_i)
);

// File: tb/tb_phy_regport_master.sv
`timescale 1ns/1ps
module tb_phy_regport_master;

  localparam int NP = 2;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int P  = 20;   // poll spacing in cycles at 2 MHz nominal, 10 us
  localparam int S  = 2;    // settle cycles, 1 us
  localparam int MP = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_phy, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy, done;
  logic [2:0]    err_code;
  logic [DW-1:0] rdata;
  logic [NP-1:0] phy_sel, phy_rd_en, phy_wr_en, phy_ack;
  logic [NP*AW-1:0] phy_addr;
  logic [NP*DW-1:0] phy_wdata, phy_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [NP-1:0] stuck_lo, stuck_hi;
  int rise_dly, fall_dly;
  logic [DW-1:0] exp_mem [NP][16];

  always #4 clk = ~clk;

  phy_regport_master #(
    .NUM_PHY(NP), .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(2_000_000),
    .POLL_US(10), .SETTLE_US(1), .MAX_POLLS(MP)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_phy_i(req_phy),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .err_code_o(err_code), .rdata_o(rdata),
    .phy_sel_o(phy_sel), .phy_addr_o(phy_addr), .phy_wdata_o(phy_wdata),
    .phy_rd_en_o(phy_rd_en), .phy_wr_en_o(phy_wr_en),
    .phy_ack_i(phy_ack), .phy_rdata_i(phy_rdata)
  );

  function automatic logic [DW-1:0] init_val(int p, int a);
    return 32'h5A00_0000 ^ (p << 8) ^ (a * 32'h0101_0101);
  endfunction

  // Four-phase PHY register port model
  for (genvar g = 0; g < NP; g++) begin : g_phy
    logic [DW-1:0] mem [16];
    logic ack_r;
    int hi_cnt, lo_cnt;
    wire en = phy_rd_en[g] | phy_wr_en[g];
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ack_r <= 1'b0; hi_cnt <= 0; lo_cnt <= 0;
        for (int i = 0; i < 16; i++) mem[i] <= init_val(g, i);
      end else begin
        if (en) begin
          lo_cnt <= 0; hi_cnt <= hi_cnt + 1;
          if (!stuck_lo[g] && !ack_r && hi_cnt >= rise_dly) begin
            ack_r <= 1'b1;
            if (phy_wr_en[g]) mem[phy_addr[g*AW +: 4]] <= phy_wdata[g*DW +: DW];
          end
        end else begin
          hi_cnt <= 0; lo_cnt <= lo_cnt + 1;
          if (lo_cnt >= fall_dly) ack_r <= 1'b0;
        end
        if (stuck_hi[g]) ack_r <= 1'b1;
      end
    end
    assign phy_ack[g] = ack_r;
    assign phy_rdata[g*DW +: DW] = mem[phy_addr[g*AW +: 4]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic p, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit intrude,
                        output int lat, output logic [2:0] code, output logic [DW-1:0] rd);
    bit multi;
    int n;
    multi = 0;
    @(negedge clk);
    req_phy = p; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'hDEAD_BEEF;
    end
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if ($countones({phy_rd_en, phy_wr_en}) > 1) multi = 1;
      if (intrude && n <= 2)
        check(!req_ready && busy, "R2", "ready/busy during op", {req_ready, busy}, 2'b01);
      if (n == 2) req_valid = 1'b0;
    end while (!done && n < 3000);
    lat = n; code = err_code; rd = rdata;
    check(!multi, "R9", "single enable", multi, 0);
    check(n < 3000, "R8", "done seen", n, 0);
    @(negedge clk);
    check(!done, "R8", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [2:0] code;
    logic [DW-1:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 0; req_phy = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    stuck_lo = '0; stuck_hi = '0; rise_dly = 0; fall_dly = 0;
    for (int p = 0; p < NP; p++) for (int i = 0; i < 16; i++) exp_mem[p][i] = init_val(p, i);
    repeat (4) @(negedge clk);
    // R1 reset state
    check(req_ready && !busy && !done, "R1", "ready/busy/done", {req_ready, busy, done}, 3'b100);
    check(phy_sel == 0 && phy_rd_en == 0 && phy_wr_en == 0, "R1", "phy controls",
          {phy_sel, phy_rd_en, phy_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // First write to PHY0: settle then handshake
    run_op(1'b0, 1'b1, 16'h0003, 32'h1234_5678, 0, lat, code, rd);
    exp_mem[0][3] = 32'h1234_5678;
    check(lat == S + 3 + 2*P, "R6", "first write latency", lat, S + 3 + 2*P);
    check(code == 0, "R8", "write ok code", code, 0);
    check(phy_sel == 2'b01, "R3", "select sticky on PHY0 only", phy_sel, 2'b01);

    // Read back on same PHY: no settle
    run_op(1'b0, 1'b0, 16'h0003, 32'h0, 0, lat, code, rd);
    check(rd == 32'h1234_5678, "R4", "write landed", rd, 32'h1234_5678);
    check(lat == 3 + 2*P, "R3", "no settle on second access", lat, 3 + 2*P);

    // Read with an intruding request during busy
    run_op(1'b0, 1'b0, 16'h0005, 32'h0, 1, lat, code, rd);
    check(rd == exp_mem[0][5], "R5", "read data", rd, exp_mem[0][5]);
    run_op(1'b0, 1'b0, 16'h0005, 32'h0, 0, lat, code, rd);
    check(rd == exp_mem[0][5], "R2", "intruding write ignored", rd, exp_mem[0][5]);

    // Timeouts
    stuck_lo[1] = 1'b1;
    run_op(1'b1, 1'b0, 16'h0002, 32'h0, 0, lat, code, rd);
    check(code == 3'd1, "R7", "read ack timeout code", code, 1);
    check(lat == S + 2 + (MP-1)*P, "R6", "read ack timeout latency", lat, S + 2 + (MP-1)*P);
    check(rd == exp_mem[0][5], "R5", "rdata kept on failed read", rd, exp_mem[0][5]);
    run_op(1'b1, 1'b1, 16'h0002, 32'h7, 0, lat, code, rd);
    check(code == 3'd3, "R7", "write ack timeout code", code, 3);
    check(lat == 2 + (MP-1)*P, "R6", "write ack timeout latency", lat, 2 + (MP-1)*P);
    check(phy_rd_en == 0 && phy_wr_en == 0 && !busy, "R7", "idle after timeout",
          {phy_rd_en, phy_wr_en, busy}, 0);
    stuck_lo[1] = 1'b0;
    repeat (3) @(negedge clk);
    stuck_hi[0] = 1'b1;
    repeat (2) @(negedge clk);
    run_op(1'b0, 1'b0, 16'h0001, 32'h0, 0, lat, code, rd);
    check(code == 3'd2, "R7", "read release timeout code", code, 2);
    check(lat == 3 + (MP-1)*P, "R6", "release timeout latency", lat, 3 + (MP-1)*P);
    run_op(1'b0, 1'b1, 16'h0001, 32'h9, 0, lat, code, rd);
    check(code == 3'd4, "R7", "write release timeout code", code, 4);
    stuck_hi[0] = 1'b0;
    repeat (3) @(negedge clk);

    // Random traffic with random ack delays
    for (int k = 0; k < 60; k++) begin
      logic p, w;
      logic [3:0] a;
      logic [DW-1:0] d;
      p = 1'($urandom_range(0, 1)); w = 1'($urandom_range(0, 1));
      a = 4'($urandom_range(0, 15)); d = $urandom;
      rise_dly = $urandom_range(0, 3*P); fall_dly = $urandom_range(0, 3*P);
      run_op(p, w, {12'h0, a}, d, 0, lat, code, rd);
      check(code == 0, "R8", "random op status", code, 0);
      if (w) exp_mem[p][a] = d;
      else check(rd == exp_mem[p][a], "R5", "random read data", rd, exp_mem[p][a]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule